// File: doc/BRIEF.md
# Pattern-Based Fractional Clock Divider

This block divides a fast input clock by integer, half-step and quarter-step ratios. A programmable waveform pattern is loaded into a rotating shift register whose active length is 12, 14 or 15 bits. The register advances one position on every rising edge of the input clock. Its lowest bit is registered and driven out as the divided clock. A pattern may hold several output periods, so ratios such as 2.5, 3.5 and 3.75 come from patterns whose period does not divide evenly into one bit time. For divide-by-one, a bypass path sends the input clock straight to the output.

Configuration arrives as static register-style fields: enable, bypass, preset, a 2-bit length select and a 15-bit pattern. Software reprograms the divider in a fixed order:
1. Drop enable and clear bypass.
2. Clear the select and pattern fields.
3. Write the length select.
4. Raise preset and write the pattern.
5. Drop preset and raise enable.

A small mode state machine decodes the fields each cycle. Its states are:
- OFF: enable is low.
- LOAD: preset is high.
- PASS: bypass is active.
- HALT: the reserved length select 3 is chosen.
- RUN: the divider is rotating.

The next state is chosen by priority, from highest to lowest:
1. preset leads to LOAD.
2. enable low leads to OFF.
3. bypass leads to PASS.
4. select 3 leads to HALT.
5. Otherwise the next state is RUN.

Every state can move to any other state in one cycle. The datapath acts on the state being entered at that edge.

Top module: `pattern_clk_div`

## Requirements
- R1: While reset is asserted, and after it is released with enable low, the divided output is low.
- R2: While preset is high, the pattern is loaded into the ring on every rising edge and the output is held low. On the k-th rising edge after preset falls with enable high (k = 1, 2, ...), the output becomes pattern bit (k-1) mod L. Rotation therefore starts from bit 0.
- R3: The ring length L depends on the length select: select 0 gives 12, select 1 gives 14 and select 2 gives 15. The output sequence repeats every L input cycles.
- R4: The following patterns give the listed ratios, counted as rising output edges per L-bit window:
  - Select 0: 0x0aaa gives /2 (6 edges), 0x0db6 gives /3 (4), 0x0ccc gives /4 (3), 0x0e38 gives /6 (2) and 0x0fc0 gives /12 (1).
  - Select 1: 0x36cc gives /3.5 (4), 0x3c78 gives /7 (2) and 0x3f80 gives /14 (1).
  - Select 2: 0x5294 gives /2.5 (6), 0x6666 gives /3.75 (4), 0x739c gives /5 (3), 0x78f0 gives /7.5 (2) and 0x7f80 gives /15 (1).
- R5: Pattern bits at or above L are ignored. With select 0, bits 14:12 have no effect. With select 1, bit 14 has no effect.
- R6: When enable is low, the output is driven low from the next rising edge, and the ring holds its contents. Enabling again, without a new preset, resumes the sequence from where it stopped.
- R7: Length select 3 is reserved. With enable high and bypass low, the output stays low.
- R8: With enable and bypass both high, and preset low, the output follows the input clock combinationally, whatever the length select is. With enable low, bypass has no effect and the output stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fast | input | 1 | Fast input clock to be divided |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_enable | input | 1 | Output enable; low holds the output low |
| cfg_bypass | input | 1 | Divide-by-one path: input clock to output |
| cfg_preset | input | 1 | Load and hold the pattern in the ring |
| cfg_len_sel | input | 2 | Ring length select: 0 gives 12, 1 gives 14, 2 gives 15, 3 is reserved |
| cfg_pattern | input | 15 | Waveform pattern; bit 0 is emitted first |
| clk_div | output | 1 | Divided clock output |

## Verification
The pattern path passes through one output flop:
- After preset is released, pattern bit 0 appears just after the first rising edge.
- Gating by enable, and the reserved select, take effect on the next rising edge.

The bypass path is combinational and follows the input clock within the same phase. Configuration is driven on falling edges. Divided-output samples are taken on the falling edge that follows each relevant rising edge, so exactly one register stage lies between stimulus and observation. The bypass path is sampled a quarter period into the high phase and a quarter period into the low phase of the input clock.

// File: rtl/fdiv_pkg.sv
package fdiv_pkg;

    typedef enum logic [2:0] {
        ST_OFF  = 3'd0,
        ST_LOAD = 3'd1,
        ST_PASS = 3'd2,
        ST_RUN  = 3'd3,
        ST_HALT = 3'd4
    } fdiv_state_e;

    localparam logic [1:0] SEL_RESERVED = 2'd3;

    // Active ring length for a length select, given the full pattern width.
    function automatic int ring_len(input logic [1:0] sel, input int width);
        case (sel)
            2'd0:    return width - 3;
            2'd1:    return width - 1;
            2'd2:    return width;
            default: return 0;
        endcase
    endfunction

endpackage

// File: rtl/fdiv_mode_fsm.sv
module fdiv_mode_fsm
    import fdiv_pkg::*;
#(
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             bypass,
    input  logic             preset,
    input  logic [SEL_W-1:0] len_sel,
    output fdiv_state_e      st_q,
    output logic             load,
    output logic             step,
    output logic             pass
);

    fdiv_state_e st_d;

    // Transition decode, highest priority first.
    always_comb begin
        if (preset)                     st_d = ST_LOAD;
        else if (!enable)               st_d = ST_OFF;
        else if (bypass)                st_d = ST_PASS;
        else if (len_sel == SEL_RESERVED) st_d = ST_HALT;
        else                            st_d = ST_RUN;
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_OFF;
        else        st_q <= st_d;
    end

    // Datapath controls for the state being entered.
    always_comb begin
        load = 1'b0;
        step = 1'b0;
        pass = 1'b0;
        unique case (st_d)
            ST_OFF:  ;
            ST_LOAD: load = 1'b1;
            ST_PASS: pass = 1'b1;
            ST_RUN:  step = 1'b1;
            ST_HALT: ;
            default: ;
        endcase
    end

endmodule

// File: rtl/fdiv_pattern_ring.sv
module fdiv_pattern_ring
    import fdiv_pkg::*;
#(
    parameter int PAT_W = 15,
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             step,
    input  logic [SEL_W-1:0] len_sel,
    input  logic [PAT_W-1:0] pat,
    output logic             head
);

    logic [PAT_W-1:0] sh;
    logic [PAT_W-1:0] sh_up;
    logic [PAT_W-1:0] ld_vec;
    logic [PAT_W-1:0] rot_vec;
    int               len_i;

    assign len_i = ring_len(len_sel, PAT_W);
    assign sh_up = {1'b0, sh[PAT_W-1:1]};
    assign head  = sh[0];

    // Masked load image and rotate-right within the active length.
    always_comb begin
        for (int i = 0; i < PAT_W; i++) begin
            ld_vec[i] = (i < len_i) ? pat[i] : 1'b0;
            if (i == len_i - 1)     rot_vec[i] = sh[0];
            else if (i < len_i - 1) rot_vec[i] = sh_up[i];
            else                    rot_vec[i] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)     sh <= '0;
        else if (load)  sh <= ld_vec;
        else if (step)  sh <= rot_vec;
    end

    // R5: bits beyond a 12-bit ring are empty after a load with select 0.
    p_upper_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(load) && ($past(len_sel) == '0)) |-> (sh[PAT_W-1 -: 3] == '0));

endmodule

// File: rtl/fdiv_out_stage.sv
module fdiv_out_stage (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic pass,
    input  logic head,
    output logic div_q,
    output logic clk_out
);

    always_ff @(posedge clk) begin
        if (!rst_n) div_q <= 1'b0;
        else        div_q <= run ? head : 1'b0;
    end

    assign clk_out = pass ? clk : div_q;

endmodule

// File: rtl/pattern_clk_div.sv
module pattern_clk_div
    import fdiv_pkg::*;
#(
    parameter int PAT_W = 15,
    parameter int SEL_W = 2
) (
    input  logic             clk_fast,
    input  logic             rst_n,
    input  logic             cfg_enable,
    input  logic             cfg_bypass,
    input  logic             cfg_preset,
    input  logic [SEL_W-1:0] cfg_len_sel,
    input  logic [PAT_W-1:0] cfg_pattern,
    output logic             clk_div
);

    fdiv_state_e st_q;
    logic        load;
    logic        step;
    logic        pass;
    logic        head;
    logic        div_q;

    fdiv_mode_fsm #(.SEL_W(SEL_W)) u_fsm (
        .clk     (clk_fast),
        .rst_n   (rst_n),
        .enable  (cfg_enable),
        .bypass  (cfg_bypass),
        .preset  (cfg_preset),
        .len_sel (cfg_len_sel),
        .st_q    (st_q),
        .load    (load),
        .step    (step),
        .pass    (pass)
    );

    fdiv_pattern_ring #(.PAT_W(PAT_W), .SEL_W(SEL_W)) u_ring (
        .clk     (clk_fast),
        .rst_n   (rst_n),
        .load    (load),
        .step    (step),
        .len_sel (cfg_len_sel),
        .pat     (cfg_pattern),
        .head    (head)
    );

    fdiv_out_stage u_out (
        .clk     (clk_fast),
        .rst_n   (rst_n),
        .run     (step),
        .pass    (pass),
        .head    (head),
        .div_q   (div_q),
        .clk_out (clk_div)
    );

    // R6: the output flop is low whenever the state register shows OFF.
    p_off_low_r6: assert property (@(posedge clk_fast) disable iff (!rst_n)
        (st_q == ST_OFF) |-> !div_q);

    // R7: the reserved select keeps the output flop low.
    p_halt_low_r7: assert property (@(posedge clk_fast) disable iff (!rst_n)
        (st_q == ST_HALT) |-> !div_q);

    // R2: the output flop is low while the pattern is being preset.
    p_load_low_r2: assert property (@(posedge clk_fast) disable iff (!rst_n)
        (st_q == ST_LOAD) |-> !div_q);

    // R3: rotation only follows an enabled, non-bypassed, non-preset configuration.
    p_run_needs_cfg_r3: assert property (@(posedge clk_fast) disable iff (!rst_n)
        (st_q == ST_RUN) |-> $past(cfg_enable && !cfg_bypass && !cfg_preset));

endmodule

// File: tb/pattern_clk_div_tb_top.sv
module pattern_clk_div_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int PAT_W      = 15;
    localparam int N_VEC      = 13;

    // Entry: {length select, pattern, rising edges per ring window}
    localparam logic [20:0] VEC [N_VEC] = '{
        {2'd0, 15'h0aaa, 4'd6}, {2'd0, 15'h0db6, 4'd4}, {2'd0, 15'h0ccc, 4'd3},
        {2'd0, 15'h0e38, 4'd2}, {2'd0, 15'h0fc0, 4'd1},
        {2'd1, 15'h36cc, 4'd4}, {2'd1, 15'h3c78, 4'd2}, {2'd1, 15'h3f80, 4'd1},
        {2'd2, 15'h5294, 4'd6}, {2'd2, 15'h6666, 4'd4}, {2'd2, 15'h739c, 4'd3},
        {2'd2, 15'h78f0, 4'd2}, {2'd2, 15'h7f80, 4'd1}
    };

    logic             clk_fast = 1'b0;
    logic             rst_n    = 1'b0;
    logic             cfg_enable = 1'b0;
    logic             cfg_bypass = 1'b0;
    logic             cfg_preset = 1'b0;
    logic [1:0]       cfg_len_sel = 2'd0;
    logic [PAT_W-1:0] cfg_pattern = '0;
    logic             clk_div;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk_fast = ~clk_fast;

    pattern_clk_div dut_i (
        .clk_fast    (clk_fast),
        .rst_n       (rst_n),
        .cfg_enable  (cfg_enable),
        .cfg_bypass  (cfg_bypass),
        .cfg_preset  (cfg_preset),
        .cfg_len_sel (cfg_len_sel),
        .cfg_pattern (cfg_pattern),
        .clk_div     (clk_div)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int len_of(input logic [1:0] s);
        case (s)
            2'd0:    return 12;
            2'd1:    return 14;
            2'd2:    return 15;
            default: return 0;
        endcase
    endfunction

    // Reprogramming order; the output is checked low during each preset cycle.
    task automatic program_div(input logic [1:0] s, input logic [PAT_W-1:0] p,
                               input bit en_in_preset, input int hold, input bit en_after);
        @(negedge clk_fast);
        cfg_enable = 1'b0; cfg_bypass = 1'b0; cfg_preset = 1'b0;
        cfg_len_sel = 2'd0; cfg_pattern = '0;
        @(negedge clk_fast);
        cfg_len_sel = s;
        @(negedge clk_fast);
        cfg_preset = 1'b1; cfg_pattern = p; cfg_enable = en_in_preset;
        for (int h = 0; h < hold; h++) begin
            @(negedge clk_fast);
            check(clk_div == 1'b0, "R2 preset holds output low", int'(clk_div), 0);
        end
        @(negedge clk_fast);
        cfg_preset = 1'b0; cfg_enable = en_after;
    endtask

    // Samples 2L falling edges and compares with pattern bit (k mod L).
    task automatic expect_seq(input logic [1:0] s, input logic [PAT_W-1:0] p,
                              input string req, output int pulses);
        int  len;
        int  bad;
        logic got [0:29];
        len = len_of(s);
        bad = 0;
        for (int k = 0; k < 2 * len; k++) begin
            @(negedge clk_fast);
            got[k] = clk_div;
            if (clk_div !== p[k % len]) bad++;
        end
        check(bad == 0, req, bad, 0);
        pulses = 0;
        for (int k = 0; k < len; k++)
            if (got[k] && !got[(k + len - 1) % len]) pulses++;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int pulses;

        // R1: reset and released-but-disabled state.
        repeat (4) @(negedge clk_fast);
        check(clk_div == 1'b0, "R1 output low in reset", int'(clk_div), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk_fast);
        check(clk_div == 1'b0, "R1 output low after reset", int'(clk_div), 0);

        // R3/R4: table of reference patterns.
        for (int v = 0; v < N_VEC; v++) begin
            logic [1:0]       s;
            logic [PAT_W-1:0] p;
            int               exp_p;
            s     = VEC[v][20:19];
            p     = VEC[v][18:4];
            exp_p = int'(VEC[v][3:0]);
            program_div(s, p, 1'b0, 0, 1'b1);
            expect_seq(s, p, "R3 sequence", pulses);
            check(pulses == exp_p, "R4 ratio edge count", pulses, exp_p);
        end

        // R6: disable gates the output and holds the ring; re-enable resumes.
        program_div(2'd0, 15'h0fc0, 1'b0, 0, 1'b0);
        begin
            int hi;
            hi = 0;
            for (int k = 0; k < 24; k++) begin
                @(negedge clk_fast);
                if (clk_div) hi++;
            end
            check(hi == 0, "R6 output low while disabled", hi, 0);
        end
        cfg_enable = 1'b1;
        expect_seq(2'd0, 15'h0fc0, "R6 resume from bit 0 after hold", pulses);
        // Mid-run disable: run 8 cycles (bits 6,7 high), disable at the next.
        program_div(2'd0, 15'h0fc0, 1'b0, 0, 1'b1);
        repeat (8) @(negedge clk_fast);
        check(clk_div == 1'b1, "R6 mid-run high before disable", int'(clk_div), 1);
        cfg_enable = 1'b0;
        @(negedge clk_fast);
        check(clk_div == 1'b0, "R6 gated one edge after disable", int'(clk_div), 0);
        repeat (5) @(negedge clk_fast);
        cfg_enable = 1'b1;
        @(negedge clk_fast);
        check(clk_div == 1'b1, "R6 resumes at held bit 8", int'(clk_div), 1);

        // R7: reserved select keeps output low.
        program_div(2'd3, 15'h0aaa, 1'b0, 0, 1'b1);
        begin
            int hi;
            hi = 0;
            for (int k = 0; k < 20; k++) begin
                @(negedge clk_fast);
                if (clk_div) hi++;
            end
            check(hi == 0, "R7 reserved select output low", hi, 0);
        end

        // R5: bits beyond the ring length are ignored.
        program_div(2'd0, 15'h7aaa, 1'b0, 0, 1'b1);
        expect_seq(2'd0, 15'h0aaa, "R5 bits 14:12 ignored with select 0", pulses);
        program_div(2'd1, 15'h76cc, 1'b0, 0, 1'b1);
        expect_seq(2'd1, 15'h36cc, "R5 bit 14 ignored with select 1", pulses);

        // R2: preset held with enable high, then rotation from bit 0.
        program_div(2'd2, 15'h4001, 1'b1, 4, 1'b1);
        expect_seq(2'd2, 15'h4001, "R2 start from bit 0 after preset", pulses);

        // R8: bypass follows the input clock, also with the reserved select.
        @(negedge clk_fast);
        cfg_enable = 1'b1; cfg_bypass = 1'b1; cfg_len_sel = 2'd3;
        for (int k = 0; k < 3; k++) begin
            @(posedge clk_fast); #(CLK_PERIOD/4);
            check(clk_div == 1'b1, "R8 bypass high phase", int'(clk_div), 1);
            @(negedge clk_fast); #(CLK_PERIOD/4);
            check(clk_div == 1'b0, "R8 bypass low phase", int'(clk_div), 0);
        end
        cfg_enable = 1'b0;
        begin
            int hi;
            hi = 0;
            for (int k = 0; k < 6; k++) begin
                @(posedge clk_fast); #(CLK_PERIOD/4);
                if (clk_div) hi++;
            end
            check(hi == 0, "R8 bypass ignored while disabled", hi, 0);
        end

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule